// File: doc/BRIEF.md
# Four-Lane SIMD Kernel Core

This block is a small programmable execution core. Four lanes run one instruction stream in lockstep under a single program counter. Each lane keeps its own private bank of sixteen 32-bit registers. A kernel is started with a launch strobe that carries a start address, an argument base pointer, a thread-ID base and the number of active lanes (1 to 4). The core fetches 32-bit instructions from an instruction port that answers one cycle after the address is presented. It then executes integer arithmetic, special-register reads, convergent branches, loads, word stores and halfword stores across the enabled lanes.

All memory traffic, pixel writes included, leaves through one blocking request/response port. A memory instruction is broken into one request per participating lane, issued in ascending lane order, with at most one request in flight. Each request waits for its response before the next goes out, and the next instruction is fetched only after the last lane has been served. A halt instruction ends the kernel with a one-cycle completion pulse.

Instruction word: bits 31:28 opcode, 27:24 `rd` (destination, or predicate register for stores), 23:20 `rs1`, 19:16 `rs2`, 15:0 immediate `imm`, sign-extended. Opcodes: 0 halt, 1 register ALU (function in imm[2:0]), 2 add-immediate, 3 word load, 4 word store, 5 halfword store, 6 special read, 7 branch-if-equal, 8 branch-if-not-equal. Any other opcode does nothing and advances the program counter.

Top module: `simd_core`

## Requirements
- R1: While reset is held and after it is released with no launch, `busy`, `done` and `mem_req_valid` are all 0.
- R2: Opcode 1 writes `rd` = f(`rs1`,`rs2`) with imm[2:0] selecting 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right (both by the low 5 bits of `rs2`), 7 signed set-less-than (result 1 or 0). Opcode 2 writes `rd` = `rs1` + sign-extended `imm`.
- R3: Register 0 of every lane always reads as zero. A write to it has no effect.
- R4: Only lanes whose index is below the launch lane count write registers or issue memory requests. Each lane computes from its own registers.
- R5: Opcode 6 writes into `rd`, selected by imm[1:0]: 0 the lane index, 1 the thread-ID base plus the lane index, 2 the argument base.
- R6: Loads (opcode 3: `rd` = word at `rs1`+`imm`) and stores (write `rs2` to `rs1`+`imm`) issue one request per participating lane in ascending lane order. Only one request is outstanding at a time. Request fields stay stable until `mem_req_ready`. The size code is 2'b10 for a word and 2'b01 for a halfword.
- R7: For opcodes 4 and 5, a nonzero `rd` field names a predicate register. A lane whose predicate register holds zero issues no write. An `rd` field of 0 means every active lane writes.
- R8: Opcode 5 sends size 2'b01, the low 16 bits of `rs2` zero-extended in `mem_req_wdata`, and the address with bit 0 cleared.
- R9: Opcodes 7 and 8 compare `rs1` with `rs2` in lane 0 only. When the branch is taken, every lane continues at pc+1+`imm`. Otherwise every lane continues at pc+1.
- R10: Opcode 0 ends the kernel. `done` is high for exactly one cycle with `busy` low, after the last memory response. A launch presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_valid | input | 1 | Launch strobe, honoured only when idle |
| launch_pc | input | PCW | Kernel start instruction address |
| launch_arg | input | W | Argument base pointer |
| launch_tid | input | W | Thread-ID base for lane 0 |
| launch_lanes | input | LCW | Number of active lanes, 1 to LANES |
| busy | output | 1 | Kernel running |
| done | output | 1 | One-cycle completion pulse |
| imem_addr | output | PCW | Instruction word address |
| imem_rdata | input | 32 | Instruction word, valid one cycle after the address |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | W | Byte address |
| mem_req_wdata | output | W | Store data |
| mem_req_size | output | 2 | 2'b10 word, 2'b01 halfword |
| mem_req_write | output | 1 | 1 for a store, 0 for a load |
| mem_rsp_valid | input | 1 | Response for the accepted request |
| mem_rsp_rdata | input | W | Load data |

## Verification
A wrong internal state shows up at the ports as stores in the wrong order, with the wrong lane count or the wrong value. A corrupted lane register or a bad ALU result shows as wrong store data in the very next store that reads it, and a wrong branch decision shows as a different number of stores. Handshake faults, such as a second request while one is in flight, a request that changes while stalled, or a misshaped halfword, are visible in the same cycle. A wrong sequencer state shows as a missing, late or stretched completion pulse at the end of the kernel.

// File: rtl/simd_pkg.sv
`timescale 1ns/1ps
package simd_pkg;

  typedef enum logic [3:0] {
    OP_HALT  = 4'd0,
    OP_ALU   = 4'd1,
    OP_ADDI  = 4'd2,
    OP_LW    = 4'd3,
    OP_SW    = 4'd4,
    OP_SH    = 4'd5,
    OP_SREAD = 4'd6,
    OP_BEQ   = 4'd7,
    OP_BNE   = 4'd8
  } op_e;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_AND = 3'd2,
    FN_OR  = 3'd3,
    FN_XOR = 3'd4,
    FN_SLL = 3'd5,
    FN_SRL = 3'd6,
    FN_SLT = 3'd7
  } alu_fn_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_FETCH = 3'd1,
    S_EXEC  = 3'd2,
    S_MREQ  = 3'd3,
    S_MRSP  = 3'd4,
    S_DONE  = 3'd5
  } seq_e;

  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

endpackage

// File: rtl/simd_lane_alu.sv
`timescale 1ns/1ps
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_fn_e        fn,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);

  localparam int SHW = $clog2(W);

  always_comb begin
    case (fn)
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_XOR:  y = a ^ b;
      FN_SLL:  y = a << b[SHW-1:0];
      FN_SRL:  y = a >> b[SHW-1:0];
      FN_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/simd_lane_rf.sv
`timescale 1ns/1ps
module simd_lane_rf #(
  parameter int W    = 32,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic [AW-1:0] ra3,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  output logic [W-1:0]  rd3
);

  logic [W-1:0] regs_q [NREG];
  logic         wr_en;

  // register 0 is hard-wired: writes to it never reach storage
  assign wr_en = we && (waddr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[waddr] <= wdata;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
  assign rd3 = (ra3 == '0) ? '0 : regs_q[ra3];

endmodule

// File: rtl/simd_core.sv
`timescale 1ns/1ps
module simd_core
  import simd_pkg::*;
#(
  parameter int LANES = 4,
  parameter int W     = 32,
  parameter int NREG  = 16,
  parameter int PCW   = 10,
  parameter int LCW   = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_valid,
  input  logic [PCW-1:0]   launch_pc,
  input  logic [W-1:0]     launch_arg,
  input  logic [W-1:0]     launch_tid,
  input  logic [LCW-1:0]   launch_lanes,
  output logic             busy,
  output logic             done,
  output logic [PCW-1:0]   imem_addr,
  input  logic [31:0]      imem_rdata,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [W-1:0]     mem_req_addr,
  output logic [W-1:0]     mem_req_wdata,
  output logic [1:0]       mem_req_size,
  output logic             mem_req_write,
  input  logic             mem_rsp_valid,
  input  logic [W-1:0]     mem_rsp_rdata
);

  localparam int AW   = $clog2(NREG);
  localparam int LIDW = (LANES > 1) ? $clog2(LANES) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  // sequencer state
  seq_e              state_q, state_d;
  logic [PCW-1:0]    pc_q, pc_d;
  logic [LIDW-1:0]   lane_q, lane_d;
  logic [31:0]       ir_q;
  logic [LANES-1:0]  mask_q, mask_d;
  logic [W-1:0]      arg_q, tid_q;
  logic              ir_en, launch_en;

  // decode of the word in flight
  logic [31:0]       cur_ir;
  op_e               op;
  logic [AW-1:0]     rd_f, rs1_f, rs2_f;
  logic [W-1:0]      imm_ext;
  alu_fn_e           alu_fn;
  logic              use_rs2, is_mem, is_load, is_half, is_branch;
  logic              exec_wb, rsp_wb, br_take, lane_last, step;

  assign cur_ir    = (state_q == S_EXEC) ? imem_rdata : ir_q;
  assign op        = op_e'(cur_ir[31:28]);
  assign rd_f      = cur_ir[24 +: AW];
  assign rs1_f     = cur_ir[20 +: AW];
  assign rs2_f     = cur_ir[16 +: AW];
  assign imm_ext   = {{(W-16){cur_ir[15]}}, cur_ir[15:0]};
  assign use_rs2   = (op == OP_ALU);
  assign alu_fn    = use_rs2 ? alu_fn_e'(cur_ir[2:0]) : FN_ADD;
  assign is_load   = (op == OP_LW);
  assign is_half   = (op == OP_SH);
  assign is_mem    = is_load || (op == OP_SW) || is_half;
  assign is_branch = (op == OP_BEQ) || (op == OP_BNE);
  assign exec_wb   = (state_q == S_EXEC) &&
                     ((op == OP_ALU) || (op == OP_ADDI) || (op == OP_SREAD));
  assign rsp_wb    = (state_q == S_MRSP) && mem_rsp_valid && is_load;
  assign lane_last = (lane_q == LIDW'(LANES - 1));

  // lanes
  logic [W-1:0]     rd1_a [LANES];
  logic [W-1:0]     rd2_a [LANES];
  logic [W-1:0]     rd3_a [LANES];
  logic [W-1:0]     alu_y [LANES];
  logic [W-1:0]     wb_data [LANES];
  logic [LANES-1:0] lane_we, takes_part;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [W-1:0] spec_val;
    logic         pred_ok;

    simd_lane_rf #(.W(W), .NREG(NREG)) u_rf (
      .clk   (clk),
      .rst_n (rst_core_n),
      .we    (lane_we[l]),
      .waddr (rd_f),
      .wdata (wb_data[l]),
      .ra1   (rs1_f),
      .ra2   (rs2_f),
      .ra3   (rd_f),
      .rd1   (rd1_a[l]),
      .rd2   (rd2_a[l]),
      .rd3   (rd3_a[l])
    );

    simd_lane_alu #(.W(W)) u_alu (
      .fn (alu_fn),
      .a  (rd1_a[l]),
      .b  (use_rs2 ? rd2_a[l] : imm_ext),
      .y  (alu_y[l])
    );

    always_comb begin
      case (cur_ir[1:0])
        2'd0:    spec_val = W'(l);
        2'd1:    spec_val = tid_q + W'(l);
        2'd2:    spec_val = arg_q;
        default: spec_val = '0;
      endcase
    end

    assign wb_data[l]    = rsp_wb ? mem_rsp_rdata :
                           ((op == OP_SREAD) ? spec_val : alu_y[l]);
    assign pred_ok       = (rd_f == '0) || (rd3_a[l] != '0);
    assign takes_part[l] = mask_q[l] && (is_load || pred_ok);
    assign lane_we[l]    = mask_q[l] &&
                           (exec_wb || (rsp_wb && (lane_q == LIDW'(l))));
    assign mask_d[l]     = (LCW'(l) < launch_lanes);
  end

  // convergent branch: decided by lane 0 alone
  assign br_take = (rd1_a[0] == rd2_a[0]) ^ (op == OP_BNE);

  // memory request for the lane being served
  logic [W-1:0] cur_addr;
  assign cur_addr      = alu_y[lane_q];
  assign mem_req_valid = (state_q == S_MREQ) && takes_part[lane_q];
  assign mem_req_addr  = is_half ? {cur_addr[W-1:1], 1'b0} : cur_addr;
  assign mem_req_wdata = is_half ? {{(W-16){1'b0}}, rd2_a[lane_q][15:0]}
                                 : rd2_a[lane_q];
  assign mem_req_size  = is_half ? SZ_HALF : SZ_WORD;
  assign mem_req_write = !is_load;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    lane_d    = lane_q;
    ir_en     = 1'b0;
    launch_en = 1'b0;
    step      = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (launch_valid) begin
          launch_en = 1'b1;
          pc_d      = launch_pc;
          state_d   = S_FETCH;
        end
      end
      S_FETCH: state_d = S_EXEC;
      S_EXEC: begin
        ir_en = 1'b1;
        if (op == OP_HALT) begin
          state_d = S_DONE;
        end else if (is_mem) begin
          lane_d  = '0;
          state_d = S_MREQ;
        end else begin
          state_d = S_FETCH;
          if (is_branch && br_take) pc_d = pc_q + PCW'(1) + imm_ext[PCW-1:0];
          else                      pc_d = pc_q + PCW'(1);
        end
      end
      S_MREQ: begin
        if (!takes_part[lane_q]) step = 1'b1;
        else if (mem_req_ready)  state_d = S_MRSP;
      end
      S_MRSP: begin
        if (mem_rsp_valid) step = 1'b1;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (step) begin
      if (lane_last) begin
        pc_d    = pc_q + PCW'(1);
        state_d = S_FETCH;
      end else begin
        lane_d  = lane_q + LIDW'(1);
        state_d = S_MREQ;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= S_IDLE;
      pc_q    <= '0;
      lane_q  <= '0;
      ir_q    <= '0;
      mask_q  <= '0;
      arg_q   <= '0;
      tid_q   <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      lane_q  <= lane_d;
      if (ir_en) ir_q <= imem_rdata;
      if (launch_en) begin
        mask_q <= mask_d;
        arg_q  <= launch_arg;
        tid_q  <= launch_tid;
      end
    end
  end

  assign imem_addr = pc_q;
  assign busy      = (state_q != S_IDLE) && (state_q != S_DONE);
  assign done      = (state_q == S_DONE);

endmodule

// File: rtl/simd_core_chk.sv
`timescale 1ns/1ps
module simd_core_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic         mem_req_valid,
  input logic         mem_req_ready,
  input logic [W-1:0] mem_req_addr,
  input logic [W-1:0] mem_req_wdata,
  input logic [1:0]   mem_req_size,
  input logic         mem_req_write,
  input logic         mem_rsp_valid
);

  // tracks whether an accepted request still waits for its response
  logic in_flight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              in_flight <= 1'b0;
    else if (mem_req_valid && mem_req_ready) in_flight <= 1'b1;
    else if (mem_rsp_valid)                  in_flight <= 1'b0;
  end

  a_r1_idle_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  a_r6_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight |-> !mem_req_valid);

  a_r6_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_wdata) && $stable(mem_req_size) && $stable(mem_req_write));

  a_r6_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_size == 2'b10) || (mem_req_size == 2'b01));

  a_r8_halfword_shape: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && (mem_req_size == 2'b01) |->
      mem_req_write && !mem_req_addr[0] && (mem_req_wdata[W-1:16] == '0));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !in_flight);

  a_r10_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || done);

endmodule

bind simd_core simd_core_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_req_size  (mem_req_size),
  .mem_req_write (mem_req_write),
  .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/simd_core_tb.sv
`timescale 1ns/1ps
module simd_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        launch_valid = 1'b0;
  logic [9:0]  launch_pc = '0;
  logic [31:0] launch_arg = '0;
  logic [31:0] launch_tid = '0;
  logic [2:0]  launch_lanes = 3'd4;
  logic        busy, done;
  logic [9:0]  imem_addr;
  logic [31:0] imem_rdata;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;

  always #10 clk = ~clk;

  simd_core u_dut (
    .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_pc(launch_pc),
    .launch_arg(launch_arg), .launch_tid(launch_tid), .launch_lanes(launch_lanes),
    .busy(busy), .done(done), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_req_size(mem_req_size), .mem_req_write(mem_req_write),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  // memories and store log
  logic [31:0] prog [64];
  logic [31:0] dmem [256];
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  logic [1:0]  log_size [64];
  int          log_cnt = 0;
  logic [3:0]  stall_cnt = '0;
  bit          stall_en = 1'b0;

  always @(posedge clk) imem_rdata <= prog[imem_addr[5:0]];

  assign mem_req_ready = stall_en ? stall_cnt[1] : 1'b1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_rdata <= '0;
    end else begin
      stall_cnt     <= stall_cnt + 4'd1;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        if (mem_req_write) begin
          log_addr[log_cnt[5:0]] <= mem_req_addr;
          log_data[log_cnt[5:0]] <= mem_req_wdata;
          log_size[log_cnt[5:0]] <= mem_req_size;
          log_cnt <= log_cnt + 1;
        end else begin
          mem_rsp_rdata <= dmem[mem_req_addr[9:2]];
        end
      end
    end
  end

  int total = 0;
  int bad   = 0;
  int done_len;
  bit busy_in_done;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input int op, input int rd, input int rs1,
                                      input int rs2, input int imm);
    return {op[3:0], rd[3:0], rs1[3:0], rs2[3:0], imm[15:0]};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) prog[i] = enc(0, 0, 0, 0, 0);
  endtask

  task automatic run_kernel(input logic [9:0] pc, input logic [31:0] arg,
                            input logic [31:0] tid, input logic [2:0] n,
                            input bit stray, output bit busy_seen);
    int waited;
    @(negedge clk);
    launch_pc = pc; launch_arg = arg; launch_tid = tid; launch_lanes = n;
    launch_valid = 1'b1;
    @(negedge clk);
    launch_valid = 1'b0;
    busy_seen = busy;
    if (stray) begin
      repeat (4) @(negedge clk);
      launch_pc = 10'd40; launch_valid = 1'b1;
      @(negedge clk);
      launch_valid = 1'b0;
    end
    waited = 0;
    while (!done && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    chk(waited < 5000, "R10", "kernel completes", waited, 0);
    done_len = 0;
    busy_in_done = 1'b0;
    while (done && done_len < 10) begin
      done_len++;
      if (busy) busy_in_done = 1'b1;
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [2:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] y;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{3'd0, 32'd5,          32'd7,          32'd12},
    '{3'd1, 32'd3,          32'd5,          32'hFFFF_FFFE},
    '{3'd2, 32'hF0F0_F0F0,  32'h0FF0_0FF0,  32'h00F0_00F0},
    '{3'd3, 32'hF000_0000,  32'h0000_000F,  32'hF000_000F},
    '{3'd4, 32'hAAAA_AAAA,  32'hFFFF_FFFF,  32'h5555_5555},
    '{3'd5, 32'd1,          32'd31,         32'h8000_0000},
    '{3'd6, 32'h8000_0000,  32'd4,          32'h0800_0000},
    '{3'd7, 32'hFFFF_FFFF,  32'd5,          32'd1},
    '{3'd7, 32'd5,          32'hFFFF_FFFF,  32'd0},
    '{3'd5, 32'd3,          32'd33,         32'd6}
  };

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    bit bs;
    clear_prog();
    for (int i = 0; i < 256; i++) dmem[i] = '0;

    // R1: reset state, during and after reset
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req_valid, "R1", "outputs in reset",
        {busy, done, mem_req_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !mem_req_valid, "R1", "outputs after reset",
        {busy, done, mem_req_valid}, 0);

    // R2: ALU vector table, every lane loads a,b and stores f(a,b)
    prog[0] = enc(6, 3, 0, 0, 2);
    prog[1] = enc(3, 1, 3, 0, 0);
    prog[2] = enc(3, 2, 3, 0, 4);
    prog[4] = enc(4, 0, 3, 4, 8);
    prog[5] = enc(0, 0, 0, 0, 0);
    foreach (VECS[v]) begin
      prog[3] = enc(1, 4, 1, 2, int'(VECS[v].fn));
      dmem[32'h100 >> 2] = VECS[v].a;
      dmem[32'h104 >> 2] = VECS[v].b;
      base = log_cnt;
      run_kernel(10'd0, 32'h100, 32'd0, 3'd4, 1'b0, bs);
      chk(log_cnt - base == 4, "R2", "store count", log_cnt - base, 4);
      for (int l = 0; l < 4; l++)
        chk(log_data[base + l] == VECS[v].y && log_addr[base + l] == 32'h108,
            "R2", "alu result", log_data[base + l], VECS[v].y);
    end

    // R3 R4 R5 R6 R7 R8: three lanes, stalled memory port
    clear_prog();
    prog[0]  = enc(6, 1, 0, 0, 0);
    prog[1]  = enc(6, 2, 0, 0, 1);
    prog[2]  = enc(6, 3, 0, 0, 2);
    prog[3]  = enc(2, 6, 0, 0, 2);
    prog[4]  = enc(1, 5, 1, 6, 5);
    prog[5]  = enc(1, 7, 3, 5, 0);
    prog[6]  = enc(4, 0, 7, 2, 0);
    prog[7]  = enc(5, 1, 7, 2, 16'h41);
    prog[8]  = enc(2, 0, 0, 0, 5);
    prog[9]  = enc(4, 0, 3, 0, 16'h80);
    prog[10] = enc(0, 0, 0, 0, 0);
    stall_en = 1'b1;
    base = log_cnt;
    run_kernel(10'd0, 32'h200, 32'h1234_0064, 3'd3, 1'b0, bs);
    stall_en = 1'b0;
    chk(bs, "R10", "busy after launch", bs, 1);
    chk(done_len == 1 && !busy_in_done, "R10", "done pulse length", done_len, 1);
    chk(log_cnt - base == 8, "R4", "writes from three lanes only", log_cnt - base, 8);
    for (int l = 0; l < 3; l++) begin
      chk(log_addr[base + l] == 32'h200 + 4 * l && log_size[base + l] == 2'b10,
          "R6", "word store lane order", log_addr[base + l], 32'h200 + 4 * l);
      chk(log_data[base + l] == 32'h1234_0064 + l, "R5", "thread id value",
          log_data[base + l], 32'h1234_0064 + l);
    end
    for (int k = 0; k < 2; k++) begin
      chk(log_addr[base + 3 + k] == 32'h244 + 4 * k, "R8", "halfword address aligned",
          log_addr[base + 3 + k], 32'h244 + 4 * k);
      chk(log_size[base + 3 + k] == 2'b01 && log_data[base + 3 + k] == 32'h65 + k,
          "R7", "predicated halfword from lanes 1,2", log_data[base + 3 + k], 32'h65 + k);
    end
    for (int l = 0; l < 3; l++)
      chk(log_addr[base + 5 + l] == 32'h280 && log_data[base + 5 + l] == 0,
          "R3", "register 0 stays zero", log_data[base + 5 + l], 0);

    // R9: loop on a counter, then a branch decided by lane 0; stray launch (R10)
    clear_prog();
    prog[0] = enc(2, 1, 0, 0, 3);
    prog[1] = enc(6, 2, 0, 0, 0);
    prog[2] = enc(2, 1, 1, 0, 16'hFFFF);
    prog[3] = enc(4, 0, 0, 1, 16'h300);
    prog[4] = enc(8, 0, 1, 0, -3);
    prog[5] = enc(7, 0, 2, 0, 1);
    prog[6] = enc(4, 0, 0, 2, 16'h310);
    prog[7] = enc(0, 0, 0, 0, 0);
    prog[40] = enc(4, 0, 0, 0, 16'h3F0);
    prog[41] = enc(0, 0, 0, 0, 0);
    base = log_cnt;
    run_kernel(10'd0, 32'h0, 32'h0, 3'd2, 1'b1, bs);
    chk(log_cnt - base == 6, "R9", "loop store count, taken skip", log_cnt - base, 6);
    for (int k = 0; k < 6; k++)
      chk(log_addr[base + k] == 32'h300 && log_data[base + k] == 2 - k / 2,
          "R9", "loop counter value", log_data[base + k], 2 - k / 2);
    chk(done_len == 1, "R10", "done pulse after stray launch", done_len, 1);

    // R10: idle after done, a fresh launch is accepted
    base = log_cnt;
    run_kernel(10'd40, 32'h0, 32'h0, 3'd1, 1'b0, bs);
    chk(log_cnt - base == 1 && log_addr[base] == 32'h3F0, "R10", "launch accepted when idle",
        log_addr[base], 32'h3F0);
    chk(!busy && !mem_req_valid, "R1", "quiet after kernel", {busy, mem_req_valid}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule